// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder

This block turns two quadrature phase signals and an index signal from a rotary or linear encoder into a signed 32-bit position count. It also produces a direction flag and two single-cycle pulses. One pulse marks each count step. The other marks each recognised index edge. The three inputs may be asynchronous to the system clock, so each one passes through a two-stage synchroniser. Each then goes through a noise filter. The filter accepts a new level only after that level has stayed stable for three samples taken on a divided clock. A filter-enable input can bypass all three filters.

Decoding is four counts per cycle. Every legal edge on either filtered phase moves the count by one. When both phases change on the same clock, the edge is treated as an error. The count does not move, and a sticky error flag is raised. Which index edge is recognised depends on the current direction. When enabled, a recognised index edge clears the position a fixed three cycles later.

Top module: `quad_pos_decoder`

## Requirements
- R1: After synchronous reset, `position` is 0, `dir_fwd` is 1, and `count_pulse`, `index_pulse` and `trans_err` are 0.
- R2: With {A,B} stepping 00→10→11→01→00 (A leads B), each step raises `position` by 1, sets `dir_fwd` to 1 and gives exactly one `count_pulse`.
- R3: With the steps taken in the opposite order (A lags B), each step lowers `position` by 1, clears `dir_fwd` to 0 and gives exactly one `count_pulse`.
- R4: `position` wraps modulo 2^32: one step down from 0 gives 0xFFFFFFFF, and one step up from 0xFFFFFFFF gives 0.
- R5: With the filter enabled and divider N, a phase change applied just before a clock edge shows on `position` exactly 3N+4 rising edges later, counting that edge, and not one edge earlier.
- R6: `filt_div_sel` codes 0..7 select N = 1, 2, 4, 16, 32, 64, 128, 256. A divider of 8 is not selectable.
- R7: With the filter enabled, a phase pulse shorter than 3N cycles leaves `position` and `count_pulse` unaffected.
- R8: With `filt_en` at 0, a phase change shows on `position` exactly 3 rising edges after it is applied.
- R9: When `dir_fwd` is 1, only a rising filtered index edge gives a one-cycle `index_pulse`. When `dir_fwd` is 0, only a falling filtered index edge does.
- R10: When `idx_clear_en` is 1, `position` reads 0 three clock edges after the edge that raised `index_pulse`. When `idx_clear_en` is 0, an index edge leaves `position` unchanged.
- R11: When both filtered phases change on the same clock, `position` is left unchanged and `trans_err` goes to 1. It stays at 1 until `err_clear` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a_in | input | 1 | Phase A, asynchronous |
| phase_b_in | input | 1 | Phase B, asynchronous |
| index_in | input | 1 | Index marker, asynchronous |
| filt_en | input | 1 | 1 = use the noise filters, 0 = bypass them |
| filt_div_sel | input | 3 | Filter sample divider code (see R6) |
| idx_clear_en | input | 1 | 1 = a recognised index edge clears the position |
| err_clear | input | 1 | Clears the sticky transition error |
| position | output | 32 | Position count, two's complement |
| dir_fwd | output | 1 | Direction of the last legal step, 1 = forward |
| count_pulse | output | 1 | One-cycle pulse on each count step |
| index_pulse | output | 1 | One-cycle pulse on each recognised index edge |
| trans_err | output | 1 | Sticky illegal-transition flag |

## Verification
A wrong filter count or prescaler phase shows as a position change that arrives one or more edges away from the 3N+4 mark. Because of this, each latency is checked on both sides of the expected edge, for several divider codes. A stale phase register in the decoder shows on the very next step: the count moves the wrong way, moves twice, or raises the error flag. A fault in the index edge selection or in the clear pipeline shows within a few cycles of an index change. It appears as a missing or extra `index_pulse`, or as a clear that lands on the wrong edge.

// File: rtl/qd_pkg.sv
package qd_pkg;
   localparam int unsigned QD_SEL_W   = 3;
   localparam int unsigned QD_MAX_DIV = 256;

   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2,
      STEP_BAD  = 2'd3
   } qd_step_e;

   // map divider select code onto the legal prescale set (8 excluded)
   function automatic int unsigned div_of_sel(input logic [QD_SEL_W-1:0] sel);
      case (sel)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 16;
         3'd4:    return 32;
         3'd5:    return 64;
         3'd6:    return 128;
         default: return 256;
      endcase
   endfunction
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/qd_filter.sv
module qd_filter
   import qd_pkg::*;
#(
   parameter int unsigned SAMPLES = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic [QD_SEL_W-1:0] div_sel,
   input  logic                d,
   output logic                q
);
   localparam int unsigned PRE_W = $clog2(QD_MAX_DIV);
   localparam int unsigned NS_W  = $clog2(SAMPLES + 1);

   generate
      if (SAMPLES < 1) begin : g_bad_samples
         $error("qd_filter: SAMPLES must be at least 1");
      end
   endgenerate

   logic             cand;
   logic             fq;
   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] div_m1;
   logic [NS_W-1:0]  nsamp;

   assign div_m1 = PRE_W'(div_of_sel(div_sel) - 1);

   // prescaler and sample counter restart on every candidate change
   always_ff @(posedge clk) begin
      if (rst) begin
         cand  <= 1'b0;
         fq    <= 1'b0;
         pre   <= '0;
         nsamp <= NS_W'(SAMPLES);
      end else if (d != cand) begin
         cand  <= d;
         pre   <= '0;
         nsamp <= '0;
      end else if (nsamp != NS_W'(SAMPLES)) begin
         if (pre >= div_m1) begin
            pre   <= '0;
            nsamp <= nsamp + NS_W'(1);
            if (nsamp == NS_W'(SAMPLES - 1)) fq <= cand;
         end else begin
            pre <= pre + PRE_W'(1);
         end
      end
   end

   assign q = en ? fq : d;

   // R5: filtered level only ever moves to the value held as candidate
   assert_filter_cand_R5: assert property (@(posedge clk) disable iff (rst)
      (fq != $past(fq)) |-> (fq == $past(cand)));
endmodule

// File: rtl/qd_decode.sv
module qd_decode
   import qd_pkg::*;
#(
   parameter int unsigned POS_W     = 32,
   parameter int unsigned IDX_DELAY = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a,
   input  logic             b,
   input  logic             idx,
   input  logic             idx_clear_en,
   input  logic             err_clear,
   output logic [POS_W-1:0] position,
   output logic             dir_fwd,
   output logic             count_pulse,
   output logic             index_pulse,
   output logic             trans_err
);
   generate
      if (IDX_DELAY < 2) begin : g_bad_delay
         $error("qd_decode: IDX_DELAY must be at least 2");
      end
      if (POS_W < 2) begin : g_bad_width
         $error("qd_decode: POS_W must be at least 2");
      end
   endgenerate

   logic [1:0]           ab_q;
   logic                 idx_q;
   logic                 recog;
   logic [IDX_DELAY-1:0] idx_pipe;
   logic                 clear_now;
   qd_step_e             step;

   // four-per-cycle transition table, {a,b}; forward is A leading B
   always_comb begin
      case ({ab_q, a, b})
         4'b0010, 4'b1011, 4'b1101, 4'b0100: step = STEP_UP;
         4'b0001, 4'b0111, 4'b1110, 4'b1000: step = STEP_DOWN;
         4'b0011, 4'b1100, 4'b0110, 4'b1001: step = STEP_BAD;
         default:                            step = STEP_NONE;
      endcase
   end

   // rising index edge going forward, falling edge going backward
   assign recog     = dir_fwd ? (idx & ~idx_q) : (~idx & idx_q);
   assign clear_now = idx_clear_en & idx_pipe[IDX_DELAY-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         ab_q        <= 2'b00;
         idx_q       <= 1'b0;
         idx_pipe    <= '0;
         position    <= '0;
         dir_fwd     <= 1'b1;
         count_pulse <= 1'b0;
         trans_err   <= 1'b0;
      end else begin
         ab_q        <= {a, b};
         idx_q       <= idx;
         idx_pipe    <= {idx_pipe[IDX_DELAY-2:0], recog};
         count_pulse <= 1'b0;
         if (clear_now) begin
            position <= '0;
         end else if (step == STEP_UP) begin
            position    <= position + POS_W'(1);
            count_pulse <= 1'b1;
         end else if (step == STEP_DOWN) begin
            position    <= position - POS_W'(1);
            count_pulse <= 1'b1;
         end
         if (step == STEP_UP)        dir_fwd <= 1'b1;
         else if (step == STEP_DOWN) dir_fwd <= 1'b0;
         if (step == STEP_BAD)  trans_err <= 1'b1;
         else if (err_clear)    trans_err <= 1'b0;
      end
   end

   assign index_pulse = idx_pipe[0];

   assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
      count_pulse |-> ((position == $past(position) + POS_W'(1)) ||
                       (position == $past(position) - POS_W'(1))));

   assert_dir_match_R3: assert property (@(posedge clk) disable iff (rst)
      count_pulse |-> (dir_fwd == (position == $past(position) + POS_W'(1))));

   assert_index_clear_R10: assert property (@(posedge clk) disable iff (rst)
      $past(clear_now) |-> (position == '0));

   assert_bad_holds_R11: assert property (@(posedge clk) disable iff (rst)
      ($rose(trans_err) && !$past(clear_now)) |-> $stable(position));
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
   import qd_pkg::*;
#(
   parameter int unsigned POS_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FLT_SAMPLES = 3,
   parameter int unsigned IDX_DELAY   = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                phase_a_in,
   input  logic                phase_b_in,
   input  logic                index_in,
   input  logic                filt_en,
   input  logic [QD_SEL_W-1:0] filt_div_sel,
   input  logic                idx_clear_en,
   input  logic                err_clear,
   output logic [POS_W-1:0]    position,
   output logic                dir_fwd,
   output logic                count_pulse,
   output logic                index_pulse,
   output logic                trans_err
);
   localparam int unsigned N_CH = 3;

   logic [N_CH-1:0] raw_vec;
   logic [N_CH-1:0] sync_vec;
   logic [N_CH-1:0] filt_vec;

   assign raw_vec = {index_in, phase_b_in, phase_a_in};

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
         qd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_vec[ch]),
            .q   (sync_vec[ch])
         );
         qd_filter #(.SAMPLES(FLT_SAMPLES)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .en      (filt_en),
            .div_sel (filt_div_sel),
            .d       (sync_vec[ch]),
            .q       (filt_vec[ch])
         );
      end
   endgenerate

   qd_decode #(.POS_W(POS_W), .IDX_DELAY(IDX_DELAY)) u_dec (
      .clk          (clk),
      .rst          (rst),
      .a            (filt_vec[0]),
      .b            (filt_vec[1]),
      .idx          (filt_vec[2]),
      .idx_clear_en (idx_clear_en),
      .err_clear    (err_clear),
      .position     (position),
      .dir_fwd      (dir_fwd),
      .count_pulse  (count_pulse),
      .index_pulse  (index_pulse),
      .trans_err    (trans_err)
   );
endmodule

// File: tb/sim_quad_pos_decoder.sv
module sim_quad_pos_decoder;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        a_raw = 1'b0, b_raw = 1'b0, i_raw = 1'b0;
   logic        flt_en = 1'b1;
   logic [2:0]  sel = 3'd0;
   logic        clr_en = 1'b0;
   logic        eclr = 1'b0;
   logic [31:0] position;
   logic        dir_fwd, count_pulse, index_pulse, trans_err;

   int          total = 0, fails = 0;
   int          cp_cnt = 0, ip_cnt = 0;
   int          ph = 0;
   logic [31:0] exp_pos = 32'd0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   quad_pos_decoder u0 (
      .clk(clk), .rst(rst), .phase_a_in(a_raw), .phase_b_in(b_raw),
      .index_in(i_raw), .filt_en(flt_en), .filt_div_sel(sel),
      .idx_clear_en(clr_en), .err_clear(eclr), .position(position),
      .dir_fwd(dir_fwd), .count_pulse(count_pulse),
      .index_pulse(index_pulse), .trans_err(trans_err));

   always @(negedge clk) begin
      if (!rst && count_pulse) cp_cnt++;
      if (!rst && index_pulse) ip_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int div_n(input logic [2:0] s);
      case (s)
         3'd0: return 1;   3'd1: return 2;   3'd2: return 4;   3'd3: return 16;
         3'd4: return 32;  3'd5: return 64;  3'd6: return 128; default: return 256;
      endcase
   endfunction

   // drive the next Gray state at a falling edge (fwd: 00,10,11,01)
   task automatic drive_step(input bit fwd);
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      case (ph)
         0: begin a_raw = 1'b0; b_raw = 1'b0; end
         1: begin a_raw = 1'b1; b_raw = 1'b0; end
         2: begin a_raw = 1'b1; b_raw = 1'b1; end
         default: begin a_raw = 1'b0; b_raw = 1'b1; end
      endcase
   endtask

   task automatic step_wait(input bit fwd, input int cyc);
      @(negedge clk);
      drive_step(fwd);
      exp_pos = fwd ? exp_pos + 32'd1 : exp_pos - 32'd1;
      repeat (cyc) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 position", position, 32'd0);
      chk("R1 dir_fwd", {31'd0, dir_fwd}, 32'd1);
      chk("R1 pulses", {30'd0, count_pulse, index_pulse}, 32'd0);
      chk("R1 trans_err", {31'd0, trans_err}, 32'd0);
   endtask

   task automatic t_forward;
      int c0 = cp_cnt;
      for (int k = 0; k < 4; k++) step_wait(1'b1, 10);
      chk("R2 position", position, exp_pos);
      chk("R2 dir_fwd", {31'd0, dir_fwd}, 32'd1);
      chk("R2 pulse count", cp_cnt - c0, 32'd4);
   endtask

   task automatic t_reverse;
      int c0 = cp_cnt;
      for (int k = 0; k < 2; k++) step_wait(1'b0, 10);
      chk("R3 position", position, exp_pos);
      chk("R3 dir_fwd", {31'd0, dir_fwd}, 32'd0);
      chk("R3 pulse count", cp_cnt - c0, 32'd2);
   endtask

   task automatic t_latency(input logic [2:0] s);
      int n = div_n(s);
      logic [31:0] old;
      @(negedge clk);
      sel = s; flt_en = 1'b1;
      repeat (4) @(negedge clk);
      old = position;
      drive_step(1'b1);
      exp_pos = exp_pos + 32'd1;
      repeat (3*n + 3) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R5 R6 early N=%0d", n), position, old);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R5 R6 on time N=%0d", n), position, exp_pos);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_glitch;
      int c0;
      @(negedge clk);
      sel = 3'd2; flt_en = 1'b1;
      repeat (4) @(negedge clk);
      c0 = cp_cnt;
      a_raw = ~a_raw;
      repeat (5) @(negedge clk);
      a_raw = ~a_raw;
      repeat (60) @(negedge clk);
      chk("R7 position", position, exp_pos);
      chk("R7 pulses", cp_cnt - c0, 32'd0);
   endtask

   task automatic t_bypass;
      logic [31:0] old;
      @(negedge clk);
      flt_en = 1'b0;
      repeat (4) @(negedge clk);
      old = position;
      drive_step(1'b1);
      exp_pos = exp_pos + 32'd1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 early", position, old);
      @(posedge clk);
      @(negedge clk);
      chk("R8 on time", position, exp_pos);
   endtask

   task automatic t_illegal;
      @(negedge clk);
      flt_en = 1'b0;
      a_raw = ~a_raw; b_raw = ~b_raw;
      ph = (ph + 2) % 4;
      repeat (8) @(negedge clk);
      chk("R11 position held", position, exp_pos);
      chk("R11 err set", {31'd0, trans_err}, 32'd1);
      repeat (10) @(negedge clk);
      chk("R11 err sticky", {31'd0, trans_err}, 32'd1);
      eclr = 1'b1;
      @(negedge clk);
      eclr = 1'b0;
      chk("R11 err cleared", {31'd0, trans_err}, 32'd0);
      flt_en = 1'b1; sel = 3'd0;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_index;
      int i0;
      clr_en = 1'b0;
      step_wait(1'b1, 12);
      i0 = ip_cnt;
      i_raw = 1'b1;
      repeat (12) @(negedge clk);
      chk("R9 fwd rise pulse", ip_cnt - i0, 32'd1);
      chk("R10 no clear when off", position, exp_pos);
      i_raw = 1'b0;
      repeat (12) @(negedge clk);
      chk("R9 fwd fall ignored", ip_cnt - i0, 32'd1);
      step_wait(1'b0, 12);
      step_wait(1'b0, 12);
      step_wait(1'b1, 12);
      step_wait(1'b1, 12);
      step_wait(1'b0, 12);
      i0 = ip_cnt;
      i_raw = 1'b1;
      repeat (12) @(negedge clk);
      chk("R9 rev rise ignored", ip_cnt - i0, 32'd0);
      i_raw = 1'b0;
      repeat (12) @(negedge clk);
      chk("R9 rev fall pulse", ip_cnt - i0, 32'd1);
      chk("R10 nonzero before", {31'd0, (exp_pos != 32'd0)}, 32'd1);
      clr_en = 1'b1;
      i_raw = 1'b1;
      repeat (12) @(negedge clk);
      i_raw = 1'b0;
      for (int k = 0; k < 30 && !index_pulse; k++) @(negedge clk);
      chk("R10 pulse seen", {31'd0, index_pulse}, 32'd1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R10 not yet cleared", position, exp_pos);
      @(posedge clk);
      @(negedge clk);
      exp_pos = 32'd0;
      chk("R10 cleared", position, 32'd0);
      clr_en = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_wrap;
      step_wait(1'b0, 12);
      chk("R4 wrap down", position, 32'hFFFF_FFFF);
      step_wait(1'b1, 12);
      chk("R4 wrap up", position, 32'd0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_forward();
      t_reverse();
      t_latency(3'd2);
      t_latency(3'd3);
      t_latency(3'd7);
      t_latency(3'd0);
      t_glitch();
      t_bypass();
      t_illegal();
      t_index();
      t_wrap();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule